// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider with Lock Control

This block is the digital core of a tuning frequency synthesizer. It runs on the crystal clock. A reference divider produces a comparison pulse every R+1 clocks. On the synthesized side it receives one strobe each time an external dual-modulus prescaler finishes a division. It tells the prescaler whether the next division is by 33 or by 32. It emits one synthesized comparison pulse per B+1 prescaler divisions, so the VCO runs at (32·B + A + 32) times the reference frequency.

A three-state phase-frequency detector compares the two pulse trains and drives pump-up and pump-down requests. A lock controller measures the width of each phase error. It counts consecutive comparisons whose error fits a programmable window and declares lock once the count is reached. In automatic mode it then moves the charge pump to low current after a fixed number of reference periods. In manual mode a configuration bit selects the current. Every new divider word returns the loop to high current and clears lock.

Software programs the block through three write-only words selected by a two-bit address. The analog pump, loop filter and VCO sit outside the block.

Top module: `dmsynth_core`

## Requirements
- R1: `mod_sel` is high for the first A prescaler divisions after each wrap of the main counter and low for the remaining divisions. It changes only on a cycle that follows a `pre_pulse` or a divider write.
- R2: The divider word (address 0) holds A in bits [4:0] and B in bits [15:5]. `syn_pulse` is high for one cycle, in the cycle after every (B+1)-th `pre_pulse`. With a prescaler that honours `mod_sel`, its period is therefore 32·B + A + 32 clocks of the prescaler input.
- R3: The reference word (address 1) holds R in bits [REF_W-1:0]. A write to address 0 or 1 restarts the reference divider. The first `ref_pulse` then appears R+1 cycles after the write edge, and further pulses follow every R+1 cycles.
- R4: In the cycle after a divider write, `prog_err` is 1 if B < A and 0 otherwise. The 5-bit field already keeps A ≤ 32.
- R5: `pump_up` rises in the cycle after `ref_pulse`, and `pump_dn` rises in the cycle after `syn_pulse`. When both are pending, both clear at the next edge, so they are never high together. A pulse gap of d cycles gives a pump width of d cycles.
- R6: The lock word (address 2) has a window select in bits [1:0] and a count select in bits [3:2]. The window select allows an error of at most 2^w − 1 cycles. The count select requires 2^(c+1) consecutive in-window comparisons.
- R7: Each completed comparison inside the window advances the lock run. Reaching the required count sets `locked` in the next cycle. A comparison outside the window resets the run to zero and clears `locked` in the next cycle.
- R8: With bit 4 of the lock word set (automatic mode), `cp_low` rises in the cycle after the DELAY_REFS-th `ref_pulse` seen while locked. With bit 4 clear, a lock-word write sets `cp_low` to bit 5 of that word.
- R9: A divider write clears `locked`, the lock run, the detector state and `cp_low` for the next cycle, in either mode.
- R10: After synchronous reset, `mod_sel`, `syn_pulse`, `pump_up`, `pump_dn`, `locked`, `cp_low` and `prog_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word select: 0 divider, 1 reference, 2 lock |
| wr_data | input | 16 | Write data |
| pre_pulse | input | 1 | One-cycle strobe at the end of each prescaler division |
| mod_sel | output | 1 | 1 selects divide-by-33 for the current division |
| syn_pulse | output | 1 | Synthesized comparison pulse |
| ref_pulse | output | 1 | Reference comparison pulse |
| pump_up | output | 1 | Phase detector up request |
| pump_dn | output | 1 | Phase detector down request |
| locked | output | 1 | Lock status |
| cp_low | output | 1 | 1 selects low charge-pump current |
| prog_err | output | 1 | Last divider word broke B ≥ A |

## Verification
Each output is registered once behind its cause, so the timing of every result is fixed:
- The status flags `prog_err`, `locked` and `cp_low` settle in the cycle after the write or comparison that moves them.
- `ref_pulse` appears R+1 edges after a restart.
- `syn_pulse` trails the last prescaler strobe by one cycle.
- A pump pulse lasts exactly as many cycles as the two comparison pulses are apart.

The bench samples on the falling edge. It counts cycles and pulse events from a known write edge, and checks a flag in the cycle before its expected change and again in the cycle of the change, so a result that arrives one cycle early or late is caught.

// File: rtl/dmsynth_pkg.sv
`timescale 1ns/1ps
package dmsynth_pkg;
  localparam int SWAL_W = 5;
  localparam int MAIN_W = 11;
  localparam int WORD_W = SWAL_W + MAIN_W;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_REF  = 2'd1,
    SEL_LCK  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef struct packed {
    logic       man_low;
    logic       auto_en;
    logic [1:0] cnt_sel;
    logic [1:0] win_sel;
  } lock_cfg_t;
endpackage

// File: rtl/dmsynth_refdiv.sv
`timescale 1ns/1ps
module dmsynth_refdiv #(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [REF_W-1:0] r_val,
  output logic             ref_pulse
);
  logic [REF_W-1:0] rc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rc        <= '0;
      ref_pulse <= 1'b0;
    end else if (restart) begin
      rc        <= r_val;
      ref_pulse <= 1'b0;
    end else if (rc == '0) begin
      rc        <= r_val;
      ref_pulse <= 1'b1;
    end else begin
      rc        <= rc - 1'b1;
      ref_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/dmsynth_maindiv.sv
`timescale 1ns/1ps
module dmsynth_maindiv #(
  parameter int SW_W = 5,
  parameter int MN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SW_W-1:0] a_new,
  input  logic [MN_W-1:0] b_new,
  input  logic [SW_W-1:0] a_set,
  input  logic [MN_W-1:0] b_set,
  input  logic            pre_pulse,
  output logic            mod_sel,
  output logic            syn_pulse
);
  logic [MN_W-1:0] mc;
  logic [SW_W-1:0] sc;
  logic [SW_W-1:0] sc_dec;

  assign sc_dec = (sc != '0) ? sc - 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc        <= '0;
      sc        <= '0;
      mod_sel   <= 1'b0;
      syn_pulse <= 1'b0;
    end else if (load) begin
      mc        <= b_new;
      sc        <= a_new;
      mod_sel   <= (a_new != '0);
      syn_pulse <= 1'b0;
    end else if (pre_pulse) begin
      if (mc == '0) begin
        mc        <= b_set;
        sc        <= a_set;
        mod_sel   <= (a_set != '0);
        syn_pulse <= 1'b1;
      end else begin
        mc        <= mc - 1'b1;
        sc        <= sc_dec;
        mod_sel   <= (sc_dec != '0);
        syn_pulse <= 1'b0;
      end
    end else begin
      syn_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/dmsynth_pfd.sv
`timescale 1ns/1ps
module dmsynth_pfd #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ref_p,
  input  logic             syn_p,
  output logic             up,
  output logic             dn,
  output logic             done,
  output logic [ERR_W-1:0] err
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  logic             up_set, dn_set, active;
  logic [ERR_W-1:0] wc;

  assign up_set = up | ref_p;
  assign dn_set = dn | syn_p;
  assign done   = up_set & dn_set;
  assign active = up | dn;
  assign err    = (wc == ERR_MAX) ? ERR_MAX : wc + {{(ERR_W-1){1'b0}}, active};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      up <= 1'b0;
      dn <= 1'b0;
      wc <= '0;
    end else begin
      up <= up_set & ~done;
      dn <= dn_set & ~done;
      if (done)
        wc <= '0;
      else if (active && wc != ERR_MAX)
        wc <= wc + 1'b1;
    end
  end
endmodule

// File: rtl/dmsynth_lockctl.sv
`timescale 1ns/1ps
module dmsynth_lockctl #(
  parameter int ERR_W      = 8,
  parameter int RUN_W      = 5,
  parameter int DELAY_REFS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cfg_wr,
  input  logic             new_auto,
  input  logic             new_man,
  input  logic [1:0]       win_sel,
  input  logic [1:0]       cnt_sel,
  input  logic             auto_en,
  input  logic             done,
  input  logic [ERR_W-1:0] err,
  input  logic             ref_p,
  output logic             locked,
  output logic             cp_low
);
  localparam int DC_W = $clog2(DELAY_REFS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [DC_W-1:0]  DC_END  = DC_W'(DELAY_REFS);
  localparam logic [DC_W-1:0]  DC_LAST = DC_W'(DELAY_REFS - 1);

  logic [RUN_W-1:0] run;
  logic [RUN_W:0]   run_nx;
  logic [RUN_W:0]   need;
  logic [ERR_W-1:0] win;
  logic [DC_W-1:0]  dcnt;

  assign win    = ERR_W'((32'd1 << win_sel) - 32'd1);
  assign need   = (RUN_W+1)'(32'd2 << cnt_sel);
  assign run_nx = {1'b0, run} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (done) begin
      if (err <= win) begin
        if (run != RUN_MAX) run <= run_nx[RUN_W-1:0];
        if (run_nx >= need) locked <= 1'b1;
      end else begin
        run    <= '0;
        locked <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dcnt   <= '0;
      cp_low <= 1'b0;
    end else begin
      if (!locked)
        dcnt <= '0;
      else if (ref_p && !cp_low && dcnt != DC_END)
        dcnt <= dcnt + 1'b1;

      if (cfg_wr)
        cp_low <= new_man & ~new_auto;
      else if (auto_en && locked && ref_p && !cp_low && dcnt == DC_LAST)
        cp_low <= 1'b1;
    end
  end
endmodule

// File: rtl/dmsynth_core.sv
`timescale 1ns/1ps
module dmsynth_core
  import dmsynth_pkg::*;
#(
  parameter int REF_W      = 12,
  parameter int ERR_W      = 8,
  parameter int RUN_W      = 5,
  parameter int DELAY_REFS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        pre_pulse,
  output logic        mod_sel,
  output logic        syn_pulse,
  output logic        ref_pulse,
  output logic        pump_up,
  output logic        pump_dn,
  output logic        locked,
  output logic        cp_low,
  output logic        prog_err
);
  wsel_e               sel;
  logic                div_wr, ref_wr, lck_wr;
  logic [SWAL_W-1:0]   a_q, a_new;
  logic [MAIN_W-1:0]   b_q, b_new;
  logic [REF_W-1:0]    r_q, r_next;
  logic [1:0]          win_q, cnt_q;
  logic                auto_q;
  lock_cfg_t           cfg_new;
  logic                cmp_done;
  logic [ERR_W-1:0]    cmp_err;

  assign sel     = wsel_e'(wr_addr);
  assign div_wr  = wr_en && (sel == SEL_DIV);
  assign ref_wr  = wr_en && (sel == SEL_REF);
  assign lck_wr  = wr_en && (sel == SEL_LCK);
  assign a_new   = wr_data[SWAL_W-1:0];
  assign b_new   = wr_data[WORD_W-1:SWAL_W];
  assign cfg_new = lock_cfg_t'(wr_data[5:0]);
  assign r_next  = ref_wr ? wr_data[REF_W-1:0] : r_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      b_q      <= '0;
      r_q      <= '0;
      win_q    <= '0;
      cnt_q    <= '0;
      auto_q   <= 1'b0;
      prog_err <= 1'b0;
    end else begin
      if (div_wr) begin
        a_q      <= a_new;
        b_q      <= b_new;
        prog_err <= (b_new < MAIN_W'(a_new));
      end
      if (ref_wr) r_q <= wr_data[REF_W-1:0];
      if (lck_wr) begin
        win_q  <= cfg_new.win_sel;
        cnt_q  <= cfg_new.cnt_sel;
        auto_q <= cfg_new.auto_en;
      end
    end
  end

  dmsynth_refdiv #(.REF_W(REF_W)) u_ref (
    .clk       (clk),
    .rst       (rst),
    .restart   (div_wr | ref_wr),
    .r_val     (r_next),
    .ref_pulse (ref_pulse)
  );

  dmsynth_maindiv #(.SW_W(SWAL_W), .MN_W(MAIN_W)) u_main (
    .clk       (clk),
    .rst       (rst),
    .load      (div_wr),
    .a_new     (a_new),
    .b_new     (b_new),
    .a_set     (a_q),
    .b_set     (b_q),
    .pre_pulse (pre_pulse),
    .mod_sel   (mod_sel),
    .syn_pulse (syn_pulse)
  );

  dmsynth_pfd #(.ERR_W(ERR_W)) u_pfd (
    .clk   (clk),
    .rst   (rst),
    .clr   (div_wr),
    .ref_p (ref_pulse),
    .syn_p (syn_pulse),
    .up    (pump_up),
    .dn    (pump_dn),
    .done  (cmp_done),
    .err   (cmp_err)
  );

  dmsynth_lockctl #(.ERR_W(ERR_W), .RUN_W(RUN_W), .DELAY_REFS(DELAY_REFS)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .clr      (div_wr),
    .cfg_wr   (lck_wr),
    .new_auto (cfg_new.auto_en),
    .new_man  (cfg_new.man_low),
    .win_sel  (win_q),
    .cnt_sel  (cnt_q),
    .auto_en  (auto_q),
    .done     (cmp_done),
    .err      (cmp_err),
    .ref_p    (ref_pulse),
    .locked   (locked),
    .cp_low   (cp_low)
  );
endmodule

// File: rtl/dmsynth_core_chk.sv
`timescale 1ns/1ps
module dmsynth_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        pre_pulse,
  input logic        mod_sel,
  input logic        syn_pulse,
  input logic        ref_pulse,
  input logic        pump_up,
  input logic        pump_dn,
  input logic        locked,
  input logic        cp_low,
  input logic        prog_err
);
  AST_MOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pre_pulse && !(wr_en && wr_addr == 2'd0)) |=> $stable(mod_sel)); // R1

  AST_SYN_FROM_PRE: assert property (@(posedge clk) disable iff (rst)
    syn_pulse |-> $past(pre_pulse)); // R2

  AST_PROG_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=>
      (prog_err == ($past(wr_data[15:5]) < {6'd0, $past(wr_data[4:0])}))); // R4

  AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn)); // R5

  AST_UP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_up) |-> $past(ref_pulse)); // R5

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ref_pulse || syn_pulse)); // R7

  AST_LOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(cp_low) |-> $past(ref_pulse || (wr_en && wr_addr == 2'd2))); // R8

  AST_REPROG_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (!cp_low && !locked && !pump_up && !pump_dn)); // R9
endmodule

bind dmsynth_core dmsynth_core_chk chk_i (.*);

// File: tb/dmsynth_core_tb_top.sv
`timescale 1ns/1ps
module dmsynth_core_tb_top;
  localparam int LIM = 6000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd3;
  logic [15:0] wr_data = 16'd0;
  logic        presc_clr = 1'b0;
  logic        pre_pulse;
  logic        mod_sel, syn_pulse, ref_pulse, pump_up, pump_dn, locked, cp_low, prog_err;
  logic [5:0]  pcnt;

  int checks = 0;
  int fails  = 0;
  int up_seen, dn_seen;

  always #2.5 clk = ~clk;

  // behavioural 32/33 prescaler, one VCO cycle per clock
  assign pre_pulse = (pcnt == (mod_sel ? 6'd32 : 6'd31));
  always @(posedge clk) begin
    if (rst || presc_clr) pcnt <= 6'd0;
    else if (pre_pulse)   pcnt <= 6'd0;
    else                  pcnt <= pcnt + 6'd1;
  end

  dmsynth_core dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pre_pulse(pre_pulse), .mod_sel(mod_sel), .syn_pulse(syn_pulse),
    .ref_pulse(ref_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
    .locked(locked), .cp_low(cp_low), .prog_err(prog_err)
  );

  function automatic int vco_period(input int a, input int b);
    return 32 * b + a + 32;
  endfunction

  function automatic logic [15:0] div_word(input int a, input int b);
    return 16'((b << 5) | a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] addr, input logic [15:0] data, input bit clr);
    wr_en = 1'b1; wr_addr = addr; wr_data = data; presc_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd3; presc_clr = 1'b0;
  endtask

  task automatic next_ref(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
      if (pump_up) up_seen++;
      if (pump_dn) dn_seen++;
    end while (!ref_pulse && cyc < LIM);
    if (cyc >= LIM) chk(1'b0, "timeout ref", cyc, LIM);
  endtask

  task automatic next_syn(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!syn_pulse && cyc < LIM);
    if (cyc >= LIM) chk(1'b0, "timeout syn", cyc, LIM);
  endtask

  task automatic measure_syn(output int cyc, output int mods);
    cyc = 0; mods = 0;
    do begin
      if (pre_pulse && mod_sel) mods++;
      @(negedge clk); cyc++;
    end while (!syn_pulse && cyc < LIM);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c, m, a, b, n;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state, before any functional edge
    chk({mod_sel, syn_pulse, pump_up, pump_dn, locked, cp_low, prog_err} == 7'd0,
        "R10 reset outputs", {mod_sel, syn_pulse, pump_up, pump_dn, locked, cp_low, prog_err}, 0);

    // R3 reference divider period and restart
    wr(2'd1, 16'd20, 1'b0);
    next_ref(c); chk(c == 21, "R3 first ref after write", c, 21);
    next_ref(c); chk(c == 21, "R3 ref period", c, 21);

    // R1/R2 random divider words, B >= A
    for (int i = 0; i < 6; i++) begin
      a = (i == 0) ? 0 : (i == 1) ? 31 : int'($urandom % 32);
      b = a + int'($urandom % 6);
      wr(2'd0, div_word(a, b), 1'b1);
      chk(prog_err == 1'b0, "R4 valid word", prog_err, 0);
      next_syn(c);
      measure_syn(n, m);
      chk(n == vco_period(a, b), "R2 syn period", n, vco_period(a, b));
      chk(m == a, "R1 divide-by-33 count", m, a);
    end

    // R4 invalid word B < A
    wr(2'd0, div_word(9, 3), 1'b1);
    chk(prog_err == 1'b1, "R4 B<A flagged", prog_err, 1);
    wr(2'd0, div_word(3, 9), 1'b1);
    chk(prog_err == 1'b0, "R4 flag cleared", prog_err, 0);

    // Scenario: window 1, count 2, auto; ref one cycle behind syn -> error 1
    wr(2'd2, 16'h0011, 1'b0);
    wr(2'd0, div_word(2, 4), 1'b1);
    wr(2'd1, 16'd161, 1'b0);
    up_seen = 0; dn_seen = 0;
    for (int j = 1; j <= 4; j++) begin
      next_ref(c);
      if (j == 2) begin
        chk(dn_seen == 2 && up_seen == 0, "R5 dn width 1 per period", dn_seen, 2);
        chk(locked == 1'b0, "R7 not yet locked", locked, 0);
        @(negedge clk);
        chk(locked == 1'b1, "R7 locked after count", locked, 1);
      end
      if (j == 3) chk(cp_low == 1'b0, "R8 auto delay pending", cp_low, 0);
    end
    chk(cp_low == 1'b0, "R8 low not before delay", cp_low, 0);
    @(negedge clk);
    chk(cp_low == 1'b1, "R8 auto low current", cp_low, 1);

    // R7 a wide error drops lock
    next_syn(c);
    repeat (5) @(negedge clk);
    wr(2'd1, 16'd161, 1'b0);
    up_seen = 0; dn_seen = 0;
    next_ref(c);
    chk(dn_seen == 6, "R5 dn width 6", dn_seen, 6);
    chk(locked == 1'b1, "R7 lock before bad compare", locked, 1);
    @(negedge clk);
    chk(locked == 1'b0, "R7 lock cleared by wide error", locked, 0);

    // R9 reprogramming forces high current
    wr(2'd0, div_word(2, 4), 1'b1);
    chk(cp_low == 1'b0 && locked == 1'b0, "R9 reprogram clears", {cp_low, locked}, 0);

    // R6 window 0 rejects error 1
    wr(2'd2, 16'h0010, 1'b0);
    wr(2'd0, div_word(2, 4), 1'b1);
    wr(2'd1, 16'd161, 1'b0);
    for (int j = 1; j <= 4; j++) begin
      next_ref(c);
      @(negedge clk);
      chk(locked == 1'b0, "R6 window 0 never locks", locked, 0);
    end

    // R6 window 3, count 4, manual high: error 3
    wr(2'd2, 16'h0006, 1'b0);
    wr(2'd0, div_word(2, 4), 1'b1);
    repeat (2) @(negedge clk);
    wr(2'd1, 16'd161, 1'b0);
    up_seen = 0; dn_seen = 0;
    for (int j = 1; j <= 4; j++) begin
      next_ref(c);
      if (j == 1) chk(dn_seen == 3 && up_seen == 0, "R5 dn width 3", dn_seen, 3);
    end
    chk(locked == 1'b0, "R6 count 4 pending", locked, 0);
    @(negedge clk);
    chk(locked == 1'b1, "R6 locked after 4", locked, 1);
    repeat (400) @(negedge clk);
    chk(cp_low == 1'b0, "R8 manual stays high", cp_low, 0);

    // R8 manual low, R9 reprogram returns high
    wr(2'd2, 16'h0020, 1'b0);
    chk(cp_low == 1'b1, "R8 manual low", cp_low, 1);
    wr(2'd0, div_word(2, 4), 1'b1);
    chk(cp_low == 1'b0, "R9 manual cleared by reprogram", cp_low, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule